// File: doc/BRIEF.md
# Reverse Divide Special-Case Resolver

This unit sits in front of a floating-point divider for a reverse divide. The source operand is the dividend. The destination operand is the divisor, and the result replaces the destination. Both operands arrive as 80-bit extended-precision words. The unit sorts each operand into one of seven classes: zero, denormal, normal, infinity, quiet NaN, signaling NaN, or unsupported encoding.

When the outcome follows from the classes alone, the unit produces the final result word and the exception flags itself. In all other cases it raises a pass-through indication, and a core divider then computes the quotient. Rounding, the mantissa division, and overflow or underflow of finite quotients are outside this unit.

The unit accepts one operand pair on every cycle that `in_valid` is high. The result comes out exactly one cycle later. `out_write` tells the register file whether to store `out_value` into the destination.

Top module: `fdivr_special`

## Requirements
- R1: The operand word layout is: bit 79 is the sign, bits 78:64 are the biased exponent, bit 63 is the explicit integer bit, and bits 62:0 are the fraction. Bit 62 is the quiet bit of a NaN. The classes are decided as follows:
  - Exponent all ones with integer bit 1 and fraction zero is infinity.
  - Exponent all ones with integer bit 1 and a nonzero fraction is a NaN. It is quiet when bit 62 is 1 and signaling otherwise.
  - Exponent all ones with integer bit 0 is unsupported.
  - Exponent zero is zero when bits 63:0 are all 0, and denormal otherwise.
  - Any other exponent is normal when the integer bit is 1, and unsupported when it is 0.
- R2: Pass-through applies when both operands are nonzero finite (normal or denormal) and no invalid or divide-by-zero flag is raised. In that case `out_pass`=1 and `out_write`=0.
- R3: If either operand is a NaN and neither is unsupported, the result is that NaN with bit 62 forced to 1. The source NaN is preferred when both are NaNs. `out_invalid` is 1 exactly when one of the NaNs is signaling.
- R4: An unsupported encoding in either operand raises `out_invalid` and gives the default QNaN, whatever the other operand is. Infinity divided by infinity, and zero divided by zero, also raise `out_invalid` and give the default QNaN. The default QNaN is sign 1, exponent all ones, bits 63:62 = 11, and the rest 0 (0xFFFF_C000000000000000).
- R5: A nonzero finite source divided by a zero destination raises `out_zdiv`.
  - With `in_zdiv_mask`=1, the result is infinity with sign equal to the XOR of the operand signs, and `out_write`=1.
  - With `in_zdiv_mask`=0, `out_write`=0.
- R6: An infinite source divided by a zero or finite destination gives infinity with the XOR sign. No flag is raised.
- R7: The result is zero with the XOR sign, and no invalid or divide-by-zero flag, in two cases:
  - a zero or finite source divided by an infinite destination;
  - a zero source divided by a nonzero finite destination.
- R8: `out_denorm` is 1 exactly when the source operand is denormal. It does not depend on the destination.
- R9: `out_valid` goes high in the cycle after a cycle with `in_valid` high, and is low otherwise. It is low during reset and during the two clock cycles after reset release.
- R10: For each result, exactly one of `out_write` and `out_pass` is 1. The only exception is an unmasked divide-by-zero, where both are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Operand pair present this cycle |
| in_src | input | 80 | Source operand (dividend) |
| in_dst | input | 80 | Destination operand (divisor) |
| in_zdiv_mask | input | 1 | 1 = divide-by-zero masked |
| out_valid | output | 1 | Result fields valid |
| out_write | output | 1 | Store out_value into the destination |
| out_pass | output | 1 | Core divider must compute the quotient |
| out_value | output | 80 | Resolved result word |
| out_invalid | output | 1 | Invalid-operation flag |
| out_zdiv | output | 1 | Divide-by-zero flag |
| out_denorm | output | 1 | Denormal-source flag |

## Verification
The hardest situations to reach are the ones where two rules compete:
- two NaNs, one signaling, where source preference must win over signaling-ness;
- an unsupported encoding paired with a NaN;
- an infinite source over a zero divisor, which must not raise divide-by-zero.

The bench reaches each of these with hand-built encodings that put exponent, integer bit and quiet bit at the boundaries between classes. It sends them back to back so that the one-cycle latency is checked under streaming. A gap then follows to confirm that `out_valid` drops.

// File: rtl/fdivr_special_pkg.sv
package fdivr_special_pkg;
  typedef enum logic [2:0] {
    CLS_ZERO   = 3'd0,
    CLS_DENORM = 3'd1,
    CLS_NORMAL = 3'd2,
    CLS_INF    = 3'd3,
    CLS_QNAN   = 3'd4,
    CLS_SNAN   = 3'd5,
    CLS_UNSUP  = 3'd6
  } op_class_e;

  localparam int NUM_OPS = 2;
  localparam int OP_SRC  = 0;
  localparam int OP_DST  = 1;
endpackage

// File: rtl/fdr_classify.sv
module fdr_classify
  import fdivr_special_pkg::*;
#(
  parameter int EXP_W = 15,
  parameter int MAN_W = 64
) (
  input  logic [EXP_W+MAN_W:0] op_word,
  output op_class_e            op_cls
);
  localparam int W = 1 + EXP_W + MAN_W;

  logic [EXP_W-1:0] exp_f;
  logic [MAN_W-1:0] man_f;
  logic             sign_unused;

  assign {sign_unused, exp_f, man_f} = op_word;

  always_comb begin
    if (exp_f == '1) begin
      if (!man_f[MAN_W-1])          op_cls = CLS_UNSUP;
      else if (man_f[MAN_W-2:0] == '0) op_cls = CLS_INF;
      else if (man_f[MAN_W-2])      op_cls = CLS_QNAN;
      else                          op_cls = CLS_SNAN;
    end else if (exp_f == '0) begin
      op_cls = (man_f == '0) ? CLS_ZERO : CLS_DENORM;
    end else begin
      op_cls = man_f[MAN_W-1] ? CLS_NORMAL : CLS_UNSUP;
    end
  end

  logic unused_ok;
  assign unused_ok = sign_unused & (W > 0);
endmodule

// File: rtl/fdr_resolve.sv
module fdr_resolve
  import fdivr_special_pkg::*;
#(
  parameter int EXP_W = 15,
  parameter int MAN_W = 64
) (
  input  logic [EXP_W+MAN_W:0] src_word,
  input  logic [EXP_W+MAN_W:0] dst_word,
  input  op_class_e            src_cls,
  input  op_class_e            dst_cls,
  input  logic                 zdiv_mask,
  output logic [EXP_W+MAN_W:0] res_value,
  output logic                 res_write,
  output logic                 res_pass,
  output logic                 res_invalid,
  output logic                 res_zdiv,
  output logic                 res_denorm
);
  localparam int W = 1 + EXP_W + MAN_W;

  logic         sgn_x;
  logic [W-1:0] inf_w, zero_w, dnan_w, src_q, dst_q;
  logic         s_nan, d_nan, s_zero, d_zero, s_inf, d_inf;

  assign sgn_x  = src_word[W-1] ^ dst_word[W-1];
  assign inf_w  = {sgn_x, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};
  assign zero_w = {sgn_x, {(W-1){1'b0}}};
  assign dnan_w = {1'b1, {EXP_W{1'b1}}, 2'b11, {(MAN_W-2){1'b0}}};

  always_comb begin
    src_q = src_word;
    src_q[MAN_W-2] = 1'b1;
    dst_q = dst_word;
    dst_q[MAN_W-2] = 1'b1;
  end

  assign s_nan  = (src_cls == CLS_QNAN) || (src_cls == CLS_SNAN);
  assign d_nan  = (dst_cls == CLS_QNAN) || (dst_cls == CLS_SNAN);
  assign s_zero = (src_cls == CLS_ZERO);
  assign d_zero = (dst_cls == CLS_ZERO);
  assign s_inf  = (src_cls == CLS_INF);
  assign d_inf  = (dst_cls == CLS_INF);

  always_comb begin
    res_value   = '0;
    res_write   = 1'b1;
    res_pass    = 1'b0;
    res_invalid = 1'b0;
    res_zdiv    = 1'b0;
    if ((src_cls == CLS_UNSUP) || (dst_cls == CLS_UNSUP)) begin
      res_invalid = 1'b1;
      res_value   = dnan_w;
    end else if (s_nan || d_nan) begin
      res_value   = s_nan ? src_q : dst_q;
      res_invalid = (src_cls == CLS_SNAN) || (dst_cls == CLS_SNAN);
    end else if ((s_inf && d_inf) || (s_zero && d_zero)) begin
      res_invalid = 1'b1;
      res_value   = dnan_w;
    end else if (s_inf) begin
      res_value = inf_w;
    end else if (d_inf || s_zero) begin
      res_value = zero_w;
    end else if (d_zero) begin
      res_zdiv  = 1'b1;
      res_write = zdiv_mask;
      res_value = inf_w;
    end else begin
      res_pass  = 1'b1;
      res_write = 1'b0;
    end
  end

  assign res_denorm = (src_cls == CLS_DENORM);
endmodule

// File: rtl/fdivr_special.sv
module fdivr_special
  import fdivr_special_pkg::*;
#(
  parameter int EXP_W = 15,
  parameter int MAN_W = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [EXP_W+MAN_W:0] in_src,
  input  logic [EXP_W+MAN_W:0] in_dst,
  input  logic                 in_zdiv_mask,
  output logic                 out_valid,
  output logic                 out_write,
  output logic                 out_pass,
  output logic [EXP_W+MAN_W:0] out_value,
  output logic                 out_invalid,
  output logic                 out_zdiv,
  output logic                 out_denorm
);
  localparam int W = 1 + EXP_W + MAN_W;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  // classification of both operands
  logic [W-1:0] op_words [NUM_OPS];
  op_class_e    op_cls   [NUM_OPS];

  assign op_words[OP_SRC] = in_src;
  assign op_words[OP_DST] = in_dst;

  for (genvar g = 0; g < NUM_OPS; g++) begin : g_cls
    fdr_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls (
      .op_word(op_words[g]),
      .op_cls (op_cls[g])
    );
  end

  // decision
  logic [W-1:0] nx_value;
  logic         nx_write, nx_pass, nx_invalid, nx_zdiv, nx_denorm;

  fdr_resolve #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_res (
    .src_word   (in_src),
    .dst_word   (in_dst),
    .src_cls    (op_cls[OP_SRC]),
    .dst_cls    (op_cls[OP_DST]),
    .zdiv_mask  (in_zdiv_mask),
    .res_value  (nx_value),
    .res_write  (nx_write),
    .res_pass   (nx_pass),
    .res_invalid(nx_invalid),
    .res_zdiv   (nx_zdiv),
    .res_denorm (nx_denorm)
  );

  // output registers
  logic         valid_q, valid_d;
  logic [W-1:0] value_q;
  logic [4:0]   flags_q;
  logic         load_en;

  assign load_en = in_valid;
  assign valid_d = in_valid;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) valid_q <= 1'b0;
    else             valid_q <= valid_d;
  end

  always_ff @(posedge clk) begin
    if (load_en) begin
      value_q <= nx_value;
      flags_q <= {nx_write, nx_pass, nx_invalid, nx_zdiv, nx_denorm};
    end
  end

  assign out_valid = valid_q;
  assign out_value = value_q;
  assign {out_write, out_pass, out_invalid, out_zdiv, out_denorm} = flags_q;
endmodule

// File: rtl/fdivr_special_chk.sv
module fdivr_special_chk #(
  parameter int EXP_W = 15,
  parameter int MAN_W = 64
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic [EXP_W+MAN_W:0] in_src,
  input logic                 out_valid,
  input logic                 out_write,
  input logic                 out_pass,
  input logic [EXP_W+MAN_W:0] out_value,
  input logic                 out_invalid,
  input logic                 out_zdiv,
  input logic                 out_denorm
);
  localparam int W = 1 + EXP_W + MAN_W;

  logic src_is_den;
  logic res_is_nan;
  logic res_is_inf;

  assign src_is_den = (in_src[W-2 -: EXP_W] == '0) && (in_src[MAN_W-1:0] != '0);
  assign res_is_nan = (out_value[W-2 -: EXP_W] == '1) && out_value[MAN_W-1]
                      && (out_value[MAN_W-2:0] != '0);
  assign res_is_inf = (out_value[W-2 -: EXP_W] == '1) && out_value[MAN_W-1]
                      && (out_value[MAN_W-2:0] == '0);

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R9
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R9
  AST_PASS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_pass) |-> (!out_write && !out_invalid && !out_zdiv)); // R2
  AST_WRITE_XOR_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_zdiv) |-> (out_write ^ out_pass)); // R10
  AST_NAN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_write && res_is_nan) |-> out_value[MAN_W-2]); // R3
  AST_ZDIV_INF: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_zdiv && out_write) |-> (res_is_inf && !out_pass)); // R5
  AST_DENORM_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (out_denorm == $past(src_is_den))); // R8
endmodule

bind fdivr_special fdivr_special_chk #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .in_valid   (in_valid),
  .in_src     (in_src),
  .out_valid  (out_valid),
  .out_write  (out_write),
  .out_pass   (out_pass),
  .out_value  (out_value),
  .out_invalid(out_invalid),
  .out_zdiv   (out_zdiv),
  .out_denorm (out_denorm)
);

// File: tb/fdivr_special_tb.sv
module fdivr_special_tb;
  typedef struct {
    logic [79:0] value;
    logic        write;
    logic        pass;
    logic        inv;
    logic        zdiv;
    logic        den;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [79:0] in_src = '0;
  logic [79:0] in_dst = '0;
  logic        in_zdiv_mask = 1'b0;
  logic        out_valid, out_write, out_pass, out_invalid, out_zdiv, out_denorm;
  logic [79:0] out_value;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  exp_t sb[$];

  always #2.5 clk = ~clk;

  fdivr_special u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_src(in_src),
    .in_dst(in_dst), .in_zdiv_mask(in_zdiv_mask), .out_valid(out_valid),
    .out_write(out_write), .out_pass(out_pass), .out_value(out_value),
    .out_invalid(out_invalid), .out_zdiv(out_zdiv), .out_denorm(out_denorm)
  );

  function automatic logic [79:0] mk(input logic s, input logic [14:0] e, input logic [63:0] m);
    return {s, e, m};
  endfunction

  localparam logic [63:0] M_ONE = 64'h8000_0000_0000_0000;
  logic [79:0] ONE, TWO, NONE, PZ, NZ, PINF, NINF, QN_A, SN_B, SN_BQ, DEN, UNN, PSEUDO_INF, DNAN;

  initial begin
    ONE   = mk(0, 15'h3FFF, M_ONE);
    TWO   = mk(0, 15'h4000, M_ONE);
    NONE  = mk(1, 15'h3FFF, M_ONE);
    PZ    = mk(0, 15'h0000, 64'h0);
    NZ    = mk(1, 15'h0000, 64'h0);
    PINF  = mk(0, 15'h7FFF, M_ONE);
    NINF  = mk(1, 15'h7FFF, M_ONE);
    QN_A  = mk(0, 15'h7FFF, 64'hC000_0000_0000_1234);
    SN_B  = mk(1, 15'h7FFF, 64'h8000_0000_0000_0055);
    SN_BQ = mk(1, 15'h7FFF, 64'hC000_0000_0000_0055);
    DEN   = mk(0, 15'h0000, 64'h0000_0000_0000_0001);
    UNN   = mk(0, 15'h3FFF, 64'h0000_0000_0000_0001);
    PSEUDO_INF = mk(0, 15'h7FFF, 64'h0);
    DNAN  = mk(1, 15'h7FFF, 64'hC000_0000_0000_0000);
  end

  task automatic send(input logic [79:0] s, input logic [79:0] d, input logic msk,
                      input logic [79:0] ev, input logic ew, input logic ep,
                      input logic ei, input logic ez, input logic ed, input string tag);
    exp_t e;
    e.value = ev; e.write = ew; e.pass = ep; e.inv = ei; e.zdiv = ez; e.den = ed; e.tag = tag;
    sb.push_back(e);
    in_valid = 1'b1; in_src = s; in_dst = d; in_zdiv_mask = msk;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      exp_t e;
      checks++;
      if (sb.size() == 0) begin
        errors++;
        $display("FAIL R9 unexpected out_valid: actual 1 expected 0");
      end else begin
        e = sb.pop_front();
        if ({out_write, out_pass, out_invalid, out_zdiv, out_denorm} !==
            {e.write, e.pass, e.inv, e.zdiv, e.den}) begin
          errors++;
          $display("FAIL %s flags w/p/i/z/d: actual %b%b%b%b%b expected %b%b%b%b%b", e.tag,
                   out_write, out_pass, out_invalid, out_zdiv, out_denorm,
                   e.write, e.pass, e.inv, e.zdiv, e.den);
        end
        if (e.write) begin
          checks++;
          if (out_value !== e.value) begin
            errors++;
            $display("FAIL %s value: actual %h expected %h", e.tag, out_value, e.value);
          end
        end
      end
    end
  end

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired: actual running expected finished");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      errors++;
      $display("FAIL R9 reset state out_valid: actual %b expected 0", out_valid);
    end

    // R2 pass-through, R10
    send(ONE, TWO, 1'b1, '0, 0, 1, 0, 0, 0, "R2");
    // R8 denormal source still passes
    send(DEN, TWO, 1'b1, '0, 0, 1, 0, 0, 1, "R8");
    // R3 NaN propagation, R1 quiet bit
    send(QN_A, ONE, 1'b0, QN_A, 1, 0, 0, 0, 0, "R3");
    send(ONE, SN_B, 1'b0, SN_BQ, 1, 0, 1, 0, 0, "R3");
    send(QN_A, SN_B, 1'b0, QN_A, 1, 0, 1, 0, 0, "R3");
    // R4 invalid cases, R1 unsupported encodings
    send(PINF, NINF, 1'b1, DNAN, 1, 0, 1, 0, 0, "R4");
    send(PZ, NZ, 1'b1, DNAN, 1, 0, 1, 0, 0, "R4");
    send(UNN, ONE, 1'b1, DNAN, 1, 0, 1, 0, 0, "R1");
    send(QN_A, PSEUDO_INF, 1'b1, DNAN, 1, 0, 1, 0, 0, "R1");
    // R5 divide by zero
    send(NONE, PZ, 1'b1, NINF, 1, 0, 0, 1, 0, "R5");
    send(ONE, NZ, 1'b0, '0, 0, 0, 0, 1, 0, "R5");
    send(DEN, PZ, 1'b1, PINF, 1, 0, 0, 1, 1, "R5");
    // R6 infinite source
    send(NINF, TWO, 1'b0, NINF, 1, 0, 0, 0, 0, "R6");
    send(PINF, NZ, 1'b0, NINF, 1, 0, 0, 0, 0, "R6");
    // R7 zero results
    send(TWO, NINF, 1'b0, NZ, 1, 0, 0, 0, 0, "R7");
    send(NZ, NONE, 1'b0, PZ, 1, 0, 0, 0, 0, "R7");
    send(DEN, PINF, 1'b0, PZ, 1, 0, 0, 0, 1, "R7");
    send(PZ, PINF, 1'b0, PZ, 1, 0, 0, 0, 0, "R7");

    // R9 idle gap: out_valid must drop
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      errors++;
      $display("FAIL R9 idle out_valid: actual %b expected 0", out_valid);
    end
    // R10 single item after gap
    send(NONE, NONE, 1'b0, '0, 0, 1, 0, 0, 0, "R10");
    repeat (3) @(negedge clk);
    checks++;
    if (sb.size() != 0) begin
      errors++;
      $display("FAIL R9 results missing: actual %0d pending expected 0", sb.size());
    end
    done = 1'b1;
    finish_run();
  end
endmodule